// File: doc/BRIEF.md
# Fly-by DMA channel sequencer

This block is the control engine of one DMA channel that moves data between an I/O peripheral and memory without ever holding the data. When the peripheral raises its request and the channel is armed and unmasked, the sequencer asks the host for the bus with a hold request. Once the host grants hold acknowledge, the sequencer drives a memory address, one memory strobe, the opposite I/O strobe and the peripheral acknowledge all in the same cycle. The data then passes directly between the two parties on the shared data lines.

Each completed cycle advances the current address by one and lowers the remaining count by one. The count is loaded with the number of transfers minus one. The final cycle raises a terminal-count pulse. Four ways of giving up the bus are supported: single, block, demand, and an auto-reload option that restores the base address and count at terminal count so the channel stays armed. A READY input stretches a cycle. Channel programming is modelled as a one-cycle load of the base registers and the configuration.

Top module: `dma_flyby_seq`

## Requirements
- R1: A bus request (hold_req rising) starts only when the channel is armed by a load, chan_mask is low, dreq is high and hold_ack is low. A masked or unarmed channel never raises hold_req.
- R2: Address, strobes and dack are driven only after hold_ack has been seen with hold_req high. Whenever bus_oe is low, addr_out is zero and all four strobes and dack are low.
- R3: In a transfer cycle, bus_oe and dack are high. With cfg_to_io=0 (peripheral to memory), mem_wr and io_rd are high. With cfg_to_io=1 (memory to peripheral), mem_rd and io_wr are high. The other two strobes stay low.
- R4: Each completed transfer cycle (dack and ready high) advances the address presented in the next cycle by one.
- R5: tc is high exactly in the completing cycle of the last transfer. Without auto-reload, the channel then disarms and ignores dreq until the next load.
- R6: A loaded count value of N-1 produces exactly N transfers before terminal count.
- R7: With cfg_mode=2'b00 (single), hold_req drops after every transfer, and each transfer gets its own bus request.
- R8: With cfg_mode=2'b01 (block), the bus is kept from the first transfer to terminal count, even if dreq drops once dack has appeared.
- R9: With cfg_mode=2'b10 (demand), transfers continue while dreq is high. The bus is released when dreq is low at a completing cycle. Later transfers resume from the next address and remaining count.
- R10: With cfg_autoinit=1, terminal count reloads the base address and base count. The channel stays armed, and the next transfer uses the base address.
- R11: While ready is low in a transfer cycle, that cycle repeats with the same address, and address and count do not advance.
- R12: The address counter wraps from 0xFFFF to 0x0000 with no carry out of the 16-bit field.
- R13: The spare cfg_mode value 2'b11 behaves as single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DMA clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | One-cycle load of base registers and configuration; arms the channel |
| cfg_addr | input | AW | Base address |
| cfg_count | input | CW | Base count (transfers minus one) |
| cfg_mode | input | 2 | 00 single, 01 block, 10 demand, 11 spare (single) |
| cfg_autoinit | input | 1 | Reload base values at terminal count |
| cfg_to_io | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| chan_mask | input | 1 | Blocks new requests when high |
| dreq | input | 1 | Peripheral request |
| hold_ack | input | 1 | Host grant of the bus |
| ready | input | 1 | Low stretches the current transfer cycle |
| hold_req | output | 1 | Bus request to the host |
| bus_oe | output | 1 | Output enable for address and strobes |
| addr_out | output | AW | Memory address (zero when not driven) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| dack | output | 1 | Acknowledge to the peripheral |
| tc | output | 1 | Terminal-count pulse |

## Verification
The bench builds the block with a 16-bit address and an 8-bit count. With a 16-bit address, a transfer loaded near 0xFFFE crosses the page wrap within four cycles. With an 8-bit count, short counts reach terminal count many times in each mode. The host grants hold one cycle after the request, so the rule that a new request must wait for the grant to drop comes into play between single transfers. A READY pattern that goes low every third cycle stretches block transfers in the middle of a run.

// File: rtl/dfs_pkg.sv
// Shared types for the fly-by DMA channel sequencer.
// Assumes: mode encoding is fixed by the configuration port of the top.
package dfs_pkg;

    typedef enum logic [1:0] {
        XM_SINGLE = 2'b00,
        XM_BLOCK  = 2'b01,
        XM_DEMAND = 2'b10,
        XM_SPARE  = 2'b11
    } xfer_mode_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'b00,
        SQ_HOLD = 2'b01,
        SQ_MOVE = 2'b10
    } seq_state_t;

    typedef struct packed {
        xfer_mode_t mode;
        logic       autoinit;
        logic       to_io;
    } chan_cfg_t;

endpackage

// File: rtl/dfs_chan_regs.sv
// Channel register set: base and current address and count, arm flag, configuration.
// Assumes: load and step never coincide in normal use; if they do, load wins.
module dfs_chan_regs
    import dfs_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] base_addr_i,
    input  logic [CW-1:0] base_cnt_i,
    input  chan_cfg_t     cfg_i,
    input  logic          step_i,
    output logic [AW-1:0] cur_addr_o,
    output logic          cnt_last_o,
    output logic          armed_o,
    output chan_cfg_t     cfg_o
);

    logic [AW-1:0] base_addr_q;
    logic [CW-1:0] base_cnt_q;
    logic [AW-1:0] cur_addr_q;
    logic [CW-1:0] cur_cnt_q;
    logic          armed_q;
    chan_cfg_t     cfg_q;
    logic          last_w;

    assign last_w = (cur_cnt_q == '0);

    // Base copy and configuration: captured only by a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr_q <= '0;
            base_cnt_q  <= '0;
            cfg_q       <= '{mode: XM_SINGLE, autoinit: 1'b0, to_io: 1'b0};
        end else if (load_i) begin
            base_addr_q <= base_addr_i;
            base_cnt_q  <= base_cnt_i;
            cfg_q       <= cfg_i;
        end
    end

    // Working address and count: advanced per completed cycle, reloaded at the end with auto-reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_q <= '0;
            cur_cnt_q  <= '0;
        end else if (load_i) begin
            cur_addr_q <= base_addr_i;
            cur_cnt_q  <= base_cnt_i;
        end else if (step_i) begin
            if (last_w && cfg_q.autoinit) begin
                cur_addr_q <= base_addr_q;
                cur_cnt_q  <= base_cnt_q;
            end else begin
                cur_addr_q <= cur_addr_q + 1'b1;
                cur_cnt_q  <= cur_cnt_q - 1'b1;
            end
        end
    end

    // Arm flag: set by a load, cleared at terminal count unless auto-reload is on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (load_i) begin
            armed_q <= 1'b1;
        end else if (step_i && last_w && !cfg_q.autoinit) begin
            armed_q <= 1'b0;
        end
    end

    assign cur_addr_o = cur_addr_q;
    assign cnt_last_o = last_w;
    assign armed_o    = armed_q;
    assign cfg_o      = cfg_q;

endmodule

// File: rtl/dfs_seq_fsm.sv
// Bus-ownership sequencer: idle, waiting for hold grant, moving data.
// Assumes: the host keeps hold_ack high while hold_req stays high.
module dfs_seq_fsm
    import dfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       armed_i,
    input  logic       mask_i,
    input  logic       dreq_i,
    input  logic       hold_ack_i,
    input  logic       ready_i,
    input  logic       cnt_last_i,
    input  xfer_mode_t mode_i,
    output logic       hold_req_o,
    output logic       move_o,
    output logic       step_o,
    output logic       tc_o
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       keep_bus;

    // Whether the bus stays owned after a completed, non-final cycle.
    always_comb begin
        unique case (mode_i)
            XM_BLOCK:  keep_bus = 1'b1;
            XM_DEMAND: keep_bus = dreq_i;
            default:   keep_bus = 1'b0;
        endcase
    end

    assign move_o     = (state_q == SQ_MOVE);
    assign hold_req_o = (state_q != SQ_IDLE);
    assign step_o     = move_o && ready_i;
    assign tc_o       = step_o && cnt_last_i;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (armed_i && !mask_i && dreq_i && !hold_ack_i) begin
                    state_d = SQ_HOLD;
                end
            end
            SQ_HOLD: begin
                if (hold_ack_i) begin
                    state_d = SQ_MOVE;
                end
            end
            SQ_MOVE: begin
                if (step_o) begin
                    state_d = (cnt_last_i || !keep_bus) ? SQ_IDLE : SQ_MOVE;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/dfs_bus_drive.sv
// Bus output stage: gates address, strobes and acknowledge with the move state.
// Assumes: a released bus is modelled as zero values with bus_oe low.
module dfs_bus_drive #(
    parameter int AW = 16
) (
    input  logic          move_i,
    input  logic          to_io_i,
    input  logic [AW-1:0] addr_i,
    output logic          oe_o,
    output logic [AW-1:0] addr_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic          io_rd_o,
    output logic          io_wr_o,
    output logic          dack_o
);

    // Strobe pairing: memory side and I/O side always point opposite ways.
    always_comb begin
        oe_o     = move_i;
        dack_o   = move_i;
        addr_o   = move_i ? addr_i : '0;
        mem_wr_o = move_i && !to_io_i;
        io_rd_o  = move_i && !to_io_i;
        mem_rd_o = move_i &&  to_io_i;
        io_wr_o  = move_i &&  to_io_i;
    end

endmodule

// File: rtl/dma_flyby_seq.sv
// Top of one fly-by DMA channel: registers, bus sequencer and output stage.
// Assumes: cfg_load is pulsed only while the channel is idle.
module dma_flyby_seq
    import dfs_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_autoinit,
    input  logic          cfg_to_io,
    input  logic          chan_mask,
    input  logic          dreq,
    input  logic          hold_ack,
    input  logic          ready,
    output logic          hold_req,
    output logic          bus_oe,
    output logic [AW-1:0] addr_out,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          io_rd,
    output logic          io_wr,
    output logic          dack,
    output logic          tc
);

    chan_cfg_t     cfg_in;
    chan_cfg_t     cfg_now;
    logic [AW-1:0] cur_addr;
    logic          cnt_last;
    logic          armed;
    logic          move;
    logic          step;

    assign cfg_in = '{mode: xfer_mode_t'(cfg_mode), autoinit: cfg_autoinit, to_io: cfg_to_io};

    dfs_chan_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (cfg_load),
        .base_addr_i (cfg_addr),
        .base_cnt_i  (cfg_count),
        .cfg_i       (cfg_in),
        .step_i      (step),
        .cur_addr_o  (cur_addr),
        .cnt_last_o  (cnt_last),
        .armed_o     (armed),
        .cfg_o       (cfg_now)
    );

    dfs_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed_i    (armed),
        .mask_i     (chan_mask),
        .dreq_i     (dreq),
        .hold_ack_i (hold_ack),
        .ready_i    (ready),
        .cnt_last_i (cnt_last),
        .mode_i     (cfg_now.mode),
        .hold_req_o (hold_req),
        .move_o     (move),
        .step_o     (step),
        .tc_o       (tc)
    );

    dfs_bus_drive #(.AW(AW)) u_bus (
        .move_i   (move),
        .to_io_i  (cfg_now.to_io),
        .addr_i   (cur_addr),
        .oe_o     (bus_oe),
        .addr_o   (addr_out),
        .mem_rd_o (mem_rd),
        .mem_wr_o (mem_wr),
        .io_rd_o  (io_rd),
        .io_wr_o  (io_wr),
        .dack_o   (dack)
    );

endmodule

// File: rtl/dfs_checker.sv
// Port-level protocol checks for dma_flyby_seq, attached by bind.
// Assumes: the host holds hold_ack high for as long as hold_req is high.
module dfs_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hold_req,
    input logic          hold_ack,
    input logic          ready,
    input logic          bus_oe,
    input logic [AW-1:0] addr_out,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          io_rd,
    input logic          io_wr,
    input logic          dack,
    input logic          tc
);

    AST_FRESH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_req) |-> !hold_ack); // R1

    AST_BUS_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> (hold_req && hold_ack)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (addr_out == '0 && !dack && !mem_rd && !mem_wr && !io_rd && !io_wr)); // R2

    AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        dack |-> ($countones({mem_rd, mem_wr, io_rd, io_wr}) == 2 && (mem_rd == io_wr) && (mem_wr == io_rd))); // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && ready && !tc) |=> (!dack || addr_out == AW'($past(addr_out) + 1'b1))); // R4

    AST_TC_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (dack && ready)); // R5

    AST_READY_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && !ready) |=> (dack && $stable(addr_out))); // R11

endmodule

bind dma_flyby_seq dfs_checker #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_req (hold_req),
    .hold_ack (hold_ack),
    .ready    (ready),
    .bus_oe   (bus_oe),
    .addr_out (addr_out),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .dack     (dack),
    .tc       (tc)
);

// File: tb/sim_dma_flyby_seq.sv
// Bench: behavioural per-cycle model compared every clock, plus directed scenario checks.
module sim_dma_flyby_seq;
    localparam int AW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [1:0]    cfg_mode = 2'b00;
    logic          cfg_autoinit = 1'b0;
    logic          cfg_to_io = 1'b0;
    logic          chan_mask = 1'b0;
    logic          dreq = 1'b0;
    logic          hold_ack = 1'b0;
    logic          ready = 1'b1;
    logic          hold_req, bus_oe, mem_rd, mem_wr, io_rd, io_wr, dack, tc;
    logic [AW-1:0] addr_out;

    always #4 clk = ~clk;

    dma_flyby_seq #(.AW(AW), .CW(CW)) u0 (.*);

    // Host: grants hold one cycle after the request, drops it one cycle after release.
    always @(posedge clk) hold_ack <= rst_n ? hold_req : 1'b0;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit cmp_en = 0;
    string scen = "R2";

    // Reference model state.
    int            mst = 0;
    int            nxt;
    logic [AW-1:0] m_addr, m_base_a;
    logic [CW-1:0] m_cnt, m_base_c;
    logic          m_armed, m_auto, m_dir;
    logic [1:0]    m_mode;

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; m_armed = 0; m_addr = '0; m_cnt = '0;
            m_base_a = '0; m_base_c = '0; m_auto = 0; m_dir = 0; m_mode = 2'b00;
        end else begin
            nxt = mst;
            if (mst == 0) begin
                if (m_armed && !chan_mask && dreq && !hold_ack) nxt = 1;
            end else if (mst == 1) begin
                if (hold_ack) nxt = 2;
            end else if (ready) begin
                if (m_cnt == 0) begin
                    nxt = 0;
                    if (m_auto) begin m_addr = m_base_a; m_cnt = m_base_c; end
                    else begin m_armed = 0; m_addr = m_addr + 1; m_cnt = m_cnt - 1; end
                end else begin
                    m_addr = m_addr + 1; m_cnt = m_cnt - 1;
                    if (m_mode == 2'b01) nxt = 2;
                    else if (m_mode == 2'b10) nxt = dreq ? 2 : 0;
                    else nxt = 0;
                end
            end
            if (cfg_load) begin
                m_base_a = cfg_addr; m_base_c = cfg_count; m_addr = cfg_addr; m_cnt = cfg_count;
                m_armed = 1; m_auto = cfg_autoinit; m_dir = cfg_to_io; m_mode = cfg_mode;
            end
            mst = nxt;
        end
    end

    // Scenario observation logs.
    logic [AW-1:0] xq[$];
    int n_tc = 0, n_rise = 0;
    logic prev_hold = 0;

    task automatic check(input bit ok, input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        logic [AW+7:0] got, exp;
        logic mv;
        #2;
        if (cmp_en) begin
            mv  = (mst == 2);
            exp = {mst != 0, mv, mv, mv && m_dir, mv && !m_dir, mv && !m_dir, mv && m_dir,
                   mv && ready && (m_cnt == 0), mv ? m_addr : {AW{1'b0}}};
            got = {hold_req, bus_oe, dack, mem_rd, mem_wr, io_rd, io_wr, tc, addr_out};
            check(got === exp, scen, "per-cycle outputs", 64'(got), 64'(exp));
            if (dack && ready) xq.push_back(addr_out);
            if (tc) n_tc++;
            if (hold_req && !prev_hold) n_rise++;
            prev_hold = hold_req;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d cycles expected below 50000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic clear_logs();
        xq.delete(); n_tc = 0; n_rise = 0;
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [CW-1:0] c, input logic [1:0] m,
                        input logic au, input logic dir);
        @(negedge clk);
        cfg_addr = a; cfg_count = c; cfg_mode = m; cfg_autoinit = au; cfg_to_io = dir; cfg_load = 1;
        @(negedge clk);
        cfg_load = 0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle_cycles(3);
        rst_n = 1;
        @(negedge clk); #3;
        check(!hold_req && !bus_oe && !dack && !tc && addr_out == '0, "R2", "reset state",
              {hold_req, bus_oe, dack, tc}, 0);
        cmp_en = 1;

        // R1: masked channel with a request does nothing.
        scen = "R1";
        chan_mask = 1;
        load(16'h1000, 8'd2, 2'b00, 0, 0);
        clear_logs();
        dreq = 1;
        idle_cycles(12);
        check(n_rise == 0 && xq.size() == 0, "R1", "masked request ignored", n_rise, 0);

        // R7 / R6 / R5: single mode, three transfers, then no more.
        scen = "R7";
        chan_mask = 0;
        idle_cycles(30);
        check(xq.size() == 3, "R6", "transfers for count 2", xq.size(), 3);
        check(n_rise == 3, "R7", "one bus request per transfer", n_rise, 3);
        check(n_tc == 1, "R5", "terminal count pulses", n_tc, 1);
        clear_logs();
        idle_cycles(12);
        check(n_rise == 0, "R5", "disarmed after terminal count", n_rise, 0);
        dreq = 0;

        // R8 / R11 / R3: block mode to I/O, request dropped after acknowledge, READY stretching.
        scen = "R8";
        load(16'h2000, 8'd4, 2'b01, 0, 1);
        clear_logs();
        dreq = 1;
        for (int i = 0; i < 20 && !dack; i++) @(negedge clk);
        dreq = 0;
        for (int i = 0; i < 30; i++) begin
            ready = (i % 3 != 0);
            @(negedge clk);
        end
        ready = 1;
        idle_cycles(4);
        check(xq.size() == 5, "R8", "block completes after request drop", xq.size(), 5);
        check(n_rise == 1, "R8", "single bus ownership", n_rise, 1);
        for (int i = 0; i < 5 && i < xq.size(); i++)
            check(xq[i] == 16'h2000 + i, "R11", "address sequence under READY", xq[i], 16'h2000 + i);

        // R9: demand mode suspends and resumes.
        scen = "R9";
        load(16'h3000, 8'd9, 2'b10, 0, 0);
        clear_logs();
        dreq = 1; idle_cycles(7);
        dreq = 0; idle_cycles(10);
        check(xq.size() > 0 && xq.size() < 10, "R9", "partial before suspend", xq.size(), 5);
        dreq = 1; idle_cycles(30);
        dreq = 0; idle_cycles(4);
        check(xq.size() == 10, "R9", "total transfers", xq.size(), 10);
        check(n_rise == 2, "R9", "bus requests across suspend", n_rise, 2);
        for (int i = 0; i < xq.size(); i++)
            check(xq[i] == 16'h3000 + i, "R4", "contiguous resume address", xq[i], 16'h3000 + i);

        // R10: auto-reload stays armed and restarts at the base address.
        scen = "R10";
        load(16'h4000, 8'd1, 2'b00, 1, 0);
        clear_logs();
        dreq = 1; idle_cycles(40);
        chan_mask = 1; idle_cycles(4);
        dreq = 0; idle_cycles(4);
        check(xq.size() >= 4 && n_tc >= 2, "R10", "repeated terminal counts", n_tc, 2);
        for (int i = 0; i < 4 && i < xq.size(); i++)
            check(xq[i] == 16'h4000 + (i % 2), "R10", "reloaded address", xq[i], 16'h4000 + (i % 2));
        chan_mask = 0;

        // R12: wrap at the page end.
        scen = "R12";
        load(16'hFFFE, 8'd3, 2'b01, 0, 0);
        clear_logs();
        dreq = 1; idle_cycles(3); dreq = 0; idle_cycles(15);
        check(xq.size() == 4, "R12", "transfers across wrap", xq.size(), 4);
        for (int i = 0; i < 4 && i < xq.size(); i++)
            check(xq[i] == 16'(32'hFFFE + i), "R12", "wrapped address", xq[i], 16'(32'hFFFE + i));

        // R13: spare mode acts as single.
        scen = "R13";
        load(16'h5000, 8'd1, 2'b11, 0, 1);
        clear_logs();
        dreq = 1; idle_cycles(20); dreq = 0; idle_cycles(4);
        check(xq.size() == 2 && n_rise == 2, "R13", "spare mode releases per transfer", n_rise, 2);

        cmp_en = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule